// File: doc/BRIEF.md
# Bus Initiator Command Sequencer

This block is the command engine of a bus initiator controller. Software hands it a command byte through the register window, and the block updates three registers in response: the bus status byte, the auxiliary status byte and the target-LUN byte. It also tracks whether the controller is idle with the bus free or connected to a target. Four command families are carried out: software reset, disconnect, plain selection (with or without attention), and select-and-transfer. Every other code is recorded in the command register and has no further effect. Software also writes the destination ID, the target-LUN byte and the transfer count through strobed write ports.

The target side is abstracted into a small handshake. The target says whether it accepts selection. When a select-and-transfer proceeds, the target reports its current phase: status, still executing, or data. The target also reports a status code and pulses a transfer-done signal that releases the device-busy flag. While a command is executing, each read of the auxiliary status byte polls the target again. Completion is reported through a disconnect, which raises the interrupt bit. The interrupt output follows bit 7 of the auxiliary status.

All effects are registered. A strobe sampled at a rising clock edge shows on the outputs just after that edge.

Top module: `busseq_top`

## Requirements
- R1: A command strobe is ignored while auxiliary status bit 4 (command in progress) is set. The command register and all status bytes keep their values.
- R2: Code 0x00 (software reset) clears the command, target-LUN, destination-ID and transfer-count registers, then performs a disconnect. Bus status then becomes 0x01 when adv_enable is high and 0x00 when it is low.
- R3: Code 0x04 (disconnect) always clears the transfer count. When connected, it also sets bus status to 0x85 (or keeps 0x16 if it already holds 0x16), sets auxiliary status to 0x80 and returns to bus-free. When already bus-free, both status bytes stay unchanged.
- R4: Codes 0x06 and 0x07 take the target ID from the destination-ID register, set bus status to 0x42, set auxiliary status to 0x80 and clear the transfer count.
- R5: Codes 0x08 and 0x09 are refused when the device-busy flag is set or tgt_sel_ok is low. A refusal gives bus status 0x42, auxiliary status 0x80 and a transfer count of 0.
- R6: An accepted 0x08 emits an identify byte equal to the target-LUN register with bit 7 set, with ident_valid high for one cycle. Code 0x09 emits nothing.
- R7: When an accepted select-and-transfer sees tgt_phase 2'b00 (status), the block stores tgt_status into the target-LUN register and sets bus status to 0x16. It then sets auxiliary status to 0x80, ends bus-free, and does not set the busy flag.
- R8: tgt_phase 2'b01 (executing) gives auxiliary status 0x30, the connected state and the busy flag set. tgt_phase 2'b10 or 2'b11 (data) gives auxiliary status 0x31, the connected state and the busy flag clear.
- R9: While executing, a read of auxiliary status polls tgt_phase. On status, the block completes as in R7. On data, it sets auxiliary bit 0 and enters the data phase. On executing, nothing changes.
- R10: A read of bus status clears auxiliary bit 7, unless bus status is 0x16. In that case bus status becomes 0x85 and auxiliary status becomes 0x80.
- R11: A tgt_xfer_done pulse clears the device-busy flag.
- R12: Every other code (0x02 and 0x18 among them) only updates the command register. irq always equals auxiliary status bit 7.
- R13: After hardware reset, auxiliary status is 0x80, the block is bus-free, and all other registers and flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command byte strobe |
| cmd_code | input | 8 | Command byte |
| adv_enable | input | 1 | Advanced-features bit of the own-identity register |
| dst_wr | input | 1 | Destination-ID write strobe |
| dst_wdata | input | 3 | Destination ID |
| lun_wr | input | 1 | Target-LUN write strobe |
| lun_wdata | input | 8 | Target-LUN byte |
| tc_wr | input | 1 | Transfer-count write strobe |
| tc_wdata | input | TC_W | Transfer count |
| aux_rd | input | 1 | Auxiliary status read strobe |
| stat_rd | input | 1 | Bus status read strobe |
| tgt_sel_ok | input | 1 | Target present and accepts selection |
| tgt_phase | input | 2 | Target phase: 00 status, 01 executing, 1x data |
| tgt_status | input | 8 | Target status code |
| tgt_xfer_done | input | 1 | Target transfer complete pulse |
| bus_status | output | 8 | Bus status register |
| aux_status | output | 8 | Auxiliary status register |
| cmd_reg | output | 8 | Last accepted command byte |
| lun_reg | output | 8 | Target-LUN register |
| xfer_count | output | TC_W | Transfer count |
| target_id | output | 3 | Selected target ID |
| connected | output | 1 | High when not bus-free |
| dev_busy | output | 1 | Device-busy flag |
| ident_valid | output | 1 | Identify byte valid, one cycle |
| ident_byte | output | 8 | Identify message byte |
| irq | output | 1 | Interrupt, equal to auxiliary bit 7 |

## Verification
The assertions assume that software raises at most one of the command, read and write strobes in a cycle. They also assume the target inputs are steady while a strobe is sampled and that tgt_xfer_done never coincides with an accepted select-and-transfer. The stimulus changes inputs only at falling edges and gives each strobe its own cycle, so the fixed priority among simultaneous strobes never matters. The target's status, executing and data answers are set up before the command or poll they serve.

// File: rtl/busseq_pkg.sv
package busseq_pkg;

  typedef enum logic [1:0] {
    PH_FREE = 2'd0,
    PH_EXEC = 2'd1,
    PH_DATA = 2'd2
  } phase_e;

  typedef enum logic [1:0] {
    TO_STATUS = 2'd0,
    TO_EXEC   = 2'd1,
    TO_DATA   = 2'd2
  } tgt_out_e;

  typedef struct packed {
    logic sw_reset;
    logic disc;
    logic sel;
    logic selx;
    logic atn;
  } cmd_kind_t;

  localparam logic [7:0] ST_RESET     = 8'h00;
  localparam logic [7:0] ST_RESET_ADV = 8'h01;
  localparam logic [7:0] ST_DONE      = 8'h16;
  localparam logic [7:0] ST_SEL_TO    = 8'h42;
  localparam logic [7:0] ST_DISC      = 8'h85;

  localparam logic [7:0] AUX_DBR = 8'h01;
  localparam logic [7:0] AUX_CIP = 8'h10;
  localparam logic [7:0] AUX_BSY = 8'h20;
  localparam logic [7:0] AUX_INT = 8'h80;

  localparam int AUX_CIP_BIT = 4;
  localparam int AUX_INT_BIT = 7;

endpackage

// File: rtl/busseq_cmd_decode.sv
module busseq_cmd_decode
  import busseq_pkg::*;
(
  input  logic [7:0] code,
  output cmd_kind_t  kind
);

  always_comb begin
    kind = '0;
    case (code)
      8'h00: kind.sw_reset = 1'b1;
      8'h04: kind.disc     = 1'b1;
      8'h06: begin kind.sel  = 1'b1; kind.atn = 1'b1; end
      8'h07: kind.sel      = 1'b1;
      8'h08: begin kind.selx = 1'b1; kind.atn = 1'b1; end
      8'h09: kind.selx     = 1'b1;
      default: kind = '0;
    endcase
  end

endmodule

// File: rtl/busseq_tgt_outcome.sv
module busseq_tgt_outcome
  import busseq_pkg::*;
(
  input  logic [1:0] tgt_phase,
  output tgt_out_e   outc
);

  always_comb begin
    if (tgt_phase[1])      outc = TO_DATA;
    else if (tgt_phase[0]) outc = TO_EXEC;
    else                   outc = TO_STATUS;
  end

endmodule

// File: rtl/busseq_top.sv
module busseq_top
  import busseq_pkg::*;
#(
  parameter int TC_W = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  logic [7:0]      cmd_code,
  input  logic            adv_enable,
  input  logic            dst_wr,
  input  logic [2:0]      dst_wdata,
  input  logic            lun_wr,
  input  logic [7:0]      lun_wdata,
  input  logic            tc_wr,
  input  logic [TC_W-1:0] tc_wdata,
  input  logic            aux_rd,
  input  logic            stat_rd,
  input  logic            tgt_sel_ok,
  input  logic [1:0]      tgt_phase,
  input  logic [7:0]      tgt_status,
  input  logic            tgt_xfer_done,
  output logic [7:0]      bus_status,
  output logic [7:0]      aux_status,
  output logic [7:0]      cmd_reg,
  output logic [7:0]      lun_reg,
  output logic [TC_W-1:0] xfer_count,
  output logic [2:0]      target_id,
  output logic            connected,
  output logic            dev_busy,
  output logic            ident_valid,
  output logic [7:0]      ident_byte,
  output logic            irq
);

  localparam logic [7:0] IDENT_FLAG = 8'h80;

  phase_e          phase_q, n_phase;
  logic [7:0]      bus_q, n_bus;
  logic [7:0]      aux_q, n_aux;
  logic [7:0]      cmd_q, n_cmd;
  logic [7:0]      lun_q, n_lun;
  logic [2:0]      dst_q, n_dst;
  logic [2:0]      tgt_q, n_tgt;
  logic [TC_W-1:0] tc_q, n_tc;
  logic            busy_q, n_busy;
  logic            idv_q, n_idv;
  logic [7:0]      idb_q, n_idb;

  cmd_kind_t kind;
  tgt_out_e  outc;
  logic      cmd_take;
  logic      disc_req;
  logic      disc_conn;
  logic      upd_en;

  busseq_cmd_decode u_dec (
    .code (cmd_code),
    .kind (kind)
  );

  busseq_tgt_outcome u_out (
    .tgt_phase (tgt_phase),
    .outc      (outc)
  );

  assign cmd_take = cmd_valid && !aux_q[AUX_CIP_BIT];
  assign upd_en   = cmd_valid | aux_rd | stat_rd | lun_wr | dst_wr | tc_wr
                  | tgt_xfer_done | idv_q;

  // next-state logic
  always_comb begin
    n_phase   = phase_q;
    n_bus     = bus_q;
    n_aux     = aux_q;
    n_cmd     = cmd_q;
    n_lun     = lun_q;
    n_dst     = dst_q;
    n_tgt     = tgt_q;
    n_tc      = tc_q;
    n_busy    = busy_q & ~tgt_xfer_done;
    n_idv     = 1'b0;
    n_idb     = idb_q;
    disc_req  = 1'b0;
    disc_conn = (phase_q != PH_FREE);

    if (cmd_take) begin
      n_cmd = cmd_code;
      if (kind.sw_reset) begin
        n_lun    = '0;
        n_dst    = '0;
        n_tc     = '0;
        disc_req = 1'b1;
      end else if (kind.disc) begin
        disc_req = 1'b1;
      end else if (kind.sel) begin
        n_tgt = dst_q;
        n_bus = ST_SEL_TO;
        n_tc  = '0;
        n_aux = AUX_INT;
      end else if (kind.selx) begin
        n_tgt = dst_q;
        if (!busy_q && tgt_sel_ok) begin
          if (kind.atn) begin
            n_idv = 1'b1;
            n_idb = lun_q | IDENT_FLAG;
          end
          case (outc)
            TO_STATUS: begin
              n_lun     = tgt_status;
              n_bus     = ST_DONE;
              disc_req  = 1'b1;
              disc_conn = 1'b1;
            end
            TO_EXEC: begin
              n_aux   = AUX_CIP | AUX_BSY;
              n_phase = PH_EXEC;
              n_busy  = 1'b1;
            end
            default: begin
              n_aux   = AUX_CIP | AUX_BSY | AUX_DBR;
              n_phase = PH_DATA;
              n_busy  = 1'b0;
            end
          endcase
        end else begin
          n_bus = ST_SEL_TO;
          n_aux = AUX_INT;
          n_tc  = '0;
        end
      end
    end else if (aux_rd && (phase_q == PH_EXEC)) begin
      case (outc)
        TO_STATUS: begin
          n_lun    = tgt_status;
          n_bus    = ST_DONE;
          disc_req = 1'b1;
        end
        TO_DATA: begin
          n_aux   = aux_q | AUX_DBR;
          n_phase = PH_DATA;
        end
        default: n_aux = aux_q;
      endcase
    end else if (stat_rd) begin
      if (bus_q != ST_DONE) begin
        n_aux[AUX_INT_BIT] = 1'b0;
      end else begin
        n_bus = ST_DISC;
        n_aux = AUX_INT;
      end
    end else begin
      if (lun_wr) n_lun = lun_wdata;
      if (dst_wr) n_dst = dst_wdata;
      if (tc_wr)  n_tc  = tc_wdata;
    end

    if (disc_req) begin
      if (disc_conn) begin
        if (n_bus != ST_DONE) n_bus = ST_DISC;
        n_aux   = AUX_INT;
        n_phase = PH_FREE;
      end
      n_tc = '0;
      if (cmd_take && kind.sw_reset) n_bus = adv_enable ? ST_RESET_ADV : ST_RESET;
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_FREE;
      bus_q   <= ST_RESET;
      aux_q   <= AUX_INT;
      cmd_q   <= '0;
      lun_q   <= '0;
      dst_q   <= '0;
      tgt_q   <= '0;
      tc_q    <= '0;
      busy_q  <= 1'b0;
      idv_q   <= 1'b0;
      idb_q   <= '0;
    end else if (upd_en) begin
      phase_q <= n_phase;
      bus_q   <= n_bus;
      aux_q   <= n_aux;
      cmd_q   <= n_cmd;
      lun_q   <= n_lun;
      dst_q   <= n_dst;
      tgt_q   <= n_tgt;
      tc_q    <= n_tc;
      busy_q  <= n_busy;
      idv_q   <= n_idv;
      idb_q   <= n_idb;
    end
  end

  assign bus_status  = bus_q;
  assign aux_status  = aux_q;
  assign cmd_reg     = cmd_q;
  assign lun_reg     = lun_q;
  assign xfer_count  = tc_q;
  assign target_id   = tgt_q;
  assign connected   = (phase_q != PH_FREE);
  assign dev_busy    = busy_q;
  assign ident_valid = idv_q;
  assign ident_byte  = idb_q;
  assign irq         = aux_q[AUX_INT_BIT];

  // assertions
  assert_cmd_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && aux_q[AUX_CIP_BIT]) |=> $stable(cmd_q));

  assert_cip_connected_R8: assert property (@(posedge clk) disable iff (!rst_n)
    aux_q[AUX_CIP_BIT] |-> (phase_q != PH_FREE));

  assert_disconnect_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_take && cmd_code == 8'h04) |=> (tc_q == '0 && phase_q == PH_FREE));

  assert_select_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_take && (cmd_code == 8'h06 || cmd_code == 8'h07))
      |=> (bus_q == ST_SEL_TO && aux_q == AUX_INT && tc_q == '0));

  assert_refuse_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_take && kind.selx && busy_q) |=> (bus_q == ST_SEL_TO && aux_q == AUX_INT));

  assert_ident_R6: assert property (@(posedge clk) disable iff (!rst_n)
    idv_q |-> (idb_q[7] && $past(cmd_code) == 8'h08));

endmodule

// File: tb/busseq_top_test.sv
module busseq_top_test;

  localparam int CLK_PERIOD = 10;
  localparam int TC_W = 24;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            cmd_valid, adv_enable, dst_wr, lun_wr, tc_wr, aux_rd, stat_rd;
  logic [7:0]      cmd_code, lun_wdata, tgt_status;
  logic [2:0]      dst_wdata;
  logic [TC_W-1:0] tc_wdata;
  logic            tgt_sel_ok, tgt_xfer_done;
  logic [1:0]      tgt_phase;
  logic [7:0]      bus_status, aux_status, cmd_reg, lun_reg, ident_byte;
  logic [TC_W-1:0] xfer_count;
  logic [2:0]      target_id;
  logic            connected, dev_busy, ident_valid, irq;

  int checks = 0;
  int errors = 0;
  string cur_req = "R13";

  // reference model state
  int              m_phase;
  logic [7:0]      m_bus, m_aux, m_cmd, m_lun, m_idb;
  logic [2:0]      m_dst, m_tgt;
  logic [TC_W-1:0] m_tc;
  logic            m_busy, m_idv;

  busseq_top #(.TC_W(TC_W)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .adv_enable(adv_enable), .dst_wr(dst_wr), .dst_wdata(dst_wdata),
    .lun_wr(lun_wr), .lun_wdata(lun_wdata), .tc_wr(tc_wr), .tc_wdata(tc_wdata),
    .aux_rd(aux_rd), .stat_rd(stat_rd), .tgt_sel_ok(tgt_sel_ok),
    .tgt_phase(tgt_phase), .tgt_status(tgt_status), .tgt_xfer_done(tgt_xfer_done),
    .bus_status(bus_status), .aux_status(aux_status), .cmd_reg(cmd_reg),
    .lun_reg(lun_reg), .xfer_count(xfer_count), .target_id(target_id),
    .connected(connected), .dev_busy(dev_busy), .ident_valid(ident_valid),
    .ident_byte(ident_byte), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  task automatic m_disconnect(input bit was_conn);
    if (was_conn) begin
      if (m_bus != 8'h16) m_bus = 8'h85;
      m_aux = 8'h80;
      m_phase = 0;
    end
    m_tc = '0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_bus = 8'h00; m_aux = 8'h80; m_cmd = 0; m_lun = 0;
      m_dst = 0; m_tgt = 0; m_tc = 0; m_busy = 0; m_idv = 0; m_idb = 0;
    end else begin
      int kind;
      bit old_busy;
      kind = tgt_phase[1] ? 2 : (tgt_phase[0] ? 1 : 0);
      old_busy = m_busy;
      if (tgt_xfer_done) m_busy = 0;
      m_idv = 0;
      if (cmd_valid && !m_aux[4]) begin
        m_cmd = cmd_code;
        if (cmd_code == 8'h00) begin
          m_lun = 0; m_dst = 0; m_tc = 0;
          m_disconnect(m_phase != 0);
          m_bus = adv_enable ? 8'h01 : 8'h00;
        end else if (cmd_code == 8'h04) begin
          m_disconnect(m_phase != 0);
        end else if (cmd_code == 8'h06 || cmd_code == 8'h07) begin
          m_tgt = m_dst; m_bus = 8'h42; m_tc = 0; m_aux = 8'h80;
        end else if (cmd_code == 8'h08 || cmd_code == 8'h09) begin
          m_tgt = m_dst;
          if (!old_busy && tgt_sel_ok) begin
            if (cmd_code == 8'h08) begin m_idv = 1; m_idb = m_lun | 8'h80; end
            if (kind == 0) begin
              m_lun = tgt_status; m_bus = 8'h16; m_disconnect(1);
            end else if (kind == 1) begin
              m_aux = 8'h30; m_phase = 1; m_busy = 1;
            end else begin
              m_aux = 8'h31; m_phase = 2; m_busy = 0;
            end
          end else begin
            m_bus = 8'h42; m_aux = 8'h80; m_tc = 0;
          end
        end
      end else if (aux_rd && m_phase == 1) begin
        if (kind == 0) begin
          m_lun = tgt_status; m_bus = 8'h16; m_disconnect(1);
        end else if (kind == 2) begin
          m_aux = m_aux | 8'h01; m_phase = 2;
        end
      end else if (stat_rd) begin
        if (m_bus != 8'h16) m_aux[7] = 0;
        else begin m_bus = 8'h85; m_aux = 8'h80; end
      end else begin
        if (lun_wr) m_lun = lun_wdata;
        if (dst_wr) m_dst = dst_wdata;
        if (tc_wr)  m_tc  = tc_wdata;
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      logic [79:0] act, exp;
      act = {bus_status, aux_status, cmd_reg, lun_reg, xfer_count, target_id,
             connected, dev_busy, ident_valid, ident_byte, irq, 13'd0};
      exp = {m_bus, m_aux, m_cmd, m_lun, m_tc, m_tgt,
             (m_phase != 0), m_busy, m_idv, m_idb, m_aux[7], 13'd0};
      checks++;
      if (act !== exp) begin
        errors++;
        $display("FAIL %s model compare: actual %h expected %h", cur_req, act, exp);
      end
    end
  end

  task automatic chk(input string r, input [31:0] act, input [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic issue(input [7:0] c);
    @(negedge clk); cmd_valid = 1; cmd_code = c;
    @(negedge clk); cmd_valid = 0;
  endtask

  task automatic rd_aux();
    @(negedge clk); aux_rd = 1;
    @(negedge clk); aux_rd = 0;
  endtask

  task automatic rd_stat();
    @(negedge clk); stat_rd = 1;
    @(negedge clk); stat_rd = 0;
  endtask

  task automatic wr_regs(input [2:0] d, input [7:0] l, input [TC_W-1:0] t);
    @(negedge clk); dst_wr = 1; dst_wdata = d;
    @(negedge clk); dst_wr = 0; lun_wr = 1; lun_wdata = l;
    @(negedge clk); lun_wr = 0; tc_wr = 1; tc_wdata = t;
    @(negedge clk); tc_wr = 0;
  endtask

  task automatic done_pulse();
    @(negedge clk); tgt_xfer_done = 1;
    @(negedge clk); tgt_xfer_done = 0;
  endtask

  task automatic hw_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; cmd_valid = 0; cmd_code = 0; adv_enable = 0; dst_wr = 0;
    dst_wdata = 0; lun_wr = 0; lun_wdata = 0; tc_wr = 0; tc_wdata = 0;
    aux_rd = 0; stat_rd = 0; tgt_sel_ok = 0; tgt_phase = 0; tgt_status = 0;
    tgt_xfer_done = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R13 reset state
    chk("R13", aux_status, 8'h80);
    chk("R13", {bus_status, cmd_reg, lun_reg}, 24'h0);
    chk("R13", {connected, dev_busy, irq}, 3'b001);

    // R12 unsupported code only recorded
    cur_req = "R12";
    issue(8'h02);
    chk("R12", cmd_reg, 8'h02);
    chk("R12", aux_status, 8'h80);

    // R3 disconnect while bus-free
    cur_req = "R3";
    wr_regs(3'd5, 8'h03, 24'h000123);
    issue(8'h04);
    chk("R3", xfer_count, 0);
    chk("R3", {connected, aux_status}, {1'b0, 8'h80});

    // R4 plain select, then R10 status read clears irq
    cur_req = "R4";
    wr_regs(3'd5, 8'h03, 24'h000007);
    issue(8'h06);
    chk("R4", {bus_status, aux_status}, 16'h4280);
    chk("R4", {target_id, xfer_count}, {3'd5, 24'd0});
    cur_req = "R10";
    rd_stat();
    chk("R10", {irq, aux_status}, {1'b0, 8'h00});

    // R5 select-and-transfer refused, target not selectable
    cur_req = "R5";
    issue(8'h09);
    chk("R5", {bus_status, aux_status}, 16'h4280);

    // R6/R7 immediate status with attention
    cur_req = "R7";
    tgt_sel_ok = 1; tgt_phase = 2'b00; tgt_status = 8'h02;
    issue(8'h08);
    chk("R6", {ident_valid, ident_byte}, {1'b1, 8'h83});
    chk("R7", {bus_status, aux_status, lun_reg}, 24'h168002);
    chk("R7", {connected, dev_busy}, 2'b00);
    cur_req = "R10";
    rd_stat();
    chk("R10", {bus_status, aux_status}, 16'h8580);

    // R8 executing phase, R1 ignore, R9 poll to status
    cur_req = "R8";
    tgt_phase = 2'b01;
    issue(8'h09);
    chk("R8", {aux_status, connected, dev_busy}, {8'h30, 2'b11});
    chk("R6", ident_valid, 0);
    cur_req = "R1";
    issue(8'h04);
    chk("R1", {cmd_reg, aux_status, connected}, {8'h09, 8'h30, 1'b1});
    cur_req = "R9";
    rd_aux();
    chk("R9", {aux_status, connected}, {8'h30, 1'b1});
    tgt_phase = 2'b00; tgt_status = 8'h07;
    rd_aux();
    chk("R9", {bus_status, aux_status, lun_reg, connected}, {24'h168007, 1'b0});
    chk("R9", dev_busy, 1);
    cur_req = "R5";
    issue(8'h08);
    chk("R5", {bus_status, aux_status, ident_valid}, {16'h4280, 1'b0});
    cur_req = "R11";
    done_pulse();
    chk("R11", dev_busy, 0);

    // R9 poll moves to data phase
    cur_req = "R9";
    tgt_phase = 2'b01;
    issue(8'h09);
    tgt_phase = 2'b10;
    rd_aux();
    chk("R9", {aux_status, connected}, {8'h31, 1'b1});
    cur_req = "R13";
    hw_reset();

    // R8 direct data phase (2'b11 counts as data)
    cur_req = "R8";
    tgt_phase = 2'b11;
    issue(8'h09);
    chk("R8", {aux_status, connected, dev_busy}, {8'h31, 2'b10});
    cur_req = "R13";
    hw_reset();

    // R2 software reset, both flavours
    cur_req = "R2";
    rd_stat();
    wr_regs(3'd6, 8'h55, 24'h00abcd);
    adv_enable = 1;
    issue(8'h00);
    chk("R2", bus_status, 8'h01);
    chk("R2", {lun_reg, xfer_count, cmd_reg}, 0);
    chk("R2", aux_status, 8'h00);
    adv_enable = 0;
    issue(8'h00);
    chk("R2", bus_status, 8'h00);

    // R12 other codes
    cur_req = "R12";
    issue(8'h18);
    chk("R12", {cmd_reg, bus_status, aux_status}, 24'h180000);
    issue(8'hFF);
    chk("R12", {cmd_reg, irq}, {8'hFF, 1'b0});

    @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule